// File: doc/BRIEF.md
# March C Memory Self-Test with Per-Element Diagnostic Merging

This block drives a small word-organised RAM through the six-element March C algorithm, one RAM operation per clock. Every read is compared against the word the algorithm expects, and the bitwise difference (the Hamming syndrome) marks the failing bits of that word. When a word fails, the block pauses the test and shifts out a serial diagnostic record. The record carries the element index, the word address and the syndrome.

Reporting is merged per element. Syndromes from all reads of one element at one address are ORed together. A record is sent only once every operation of that element at that address has completed, so an address yields at most one record per element. A registered decode of the most recent record gives the lowest failing bit index and a flag for multi-bit failures. A sticky fault flag and a done flag complete the status seen by the test controller.

The RAM is assumed to return read data in the same cycle as the address (asynchronous read) and to write on the rising clock edge.

Top module: `mbist_march_diag`

## Requirements
- R1: After reset, `done`, `fault`, `diag_valid` and `ram_we` are all low.
- R2: A `start` pulse runs March C, one operation per cycle. The elements, by index 0..5, are: e0 (w0); e1 (r0,w1); e2 (r1,w0); e3 (r0,w1); e4 (r1,w0); e5 (r0). Data 0 means an all-zero word and data 1 an all-ones word. Elements e0, e1, e2 and e5 visit addresses 0 up to 2^AW-1, and e3 and e4 visit them from 2^AW-1 down to 0.
- R3: The syndrome of a read is the expected word XOR the read word. Syndromes of the reads of one element at one address are ORed, and the merged value is cleared at each new address. A nonzero merged value produces exactly one record, after the last operation of that element at that address. A zero merged value produces none.
- R4: A record is 3+AW+DW bits, sent on `diag_bit` one bit per clock. Field order is the element index (3 bits), then the address (AW bits), then the merged syndrome (DW bits), each field MSB first. `diag_valid` is high for exactly the record length.
- R5: While a record is shifted out, the test is paused: no RAM write occurs and the operation sequence does not advance. A run from the `start` edge to `done` takes 10*2^AW + 1 + (3+AW+DW)*records cycles.
- R6: `fault` goes high with the first record of a run, stays high until the next `start`, and is cleared by that `start`.
- R7: `err_pos` is the index of the lowest set bit of the most recent record's syndrome. `err_multi` is high when that syndrome has more than one set bit. Both are zero after a run with no record.
- R8: `done` rises after the last operation of e5 and after any record it triggered has been sent. It then stays high, with `diag_valid` and `ram_we` low, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle or done |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | DW | RAM write word |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DW | RAM read word (same-cycle) |
| done | output | 1 | Run complete |
| fault | output | 1 | Sticky: at least one record this run |
| diag_bit | output | 1 | Serial record bit |
| diag_valid | output | 1 | High while a record bit is on diag_bit |
| err_pos | output | $clog2(DW) | Lowest failing bit of the last record |
| err_multi | output | 1 | Last record had more than one failing bit |

## Verification
A wrong element, operation or address counter corrupts the session or address field of the next record. It also breaks the order in which two faulty words are reported, since e3 must report them high address first. Such an error shows within one record of the fault. A stale or uncleared syndrome accumulator shows up as an extra record, or as wrong bits in the syndrome field, at the first faulty address. A pause that fails to hold the sequence changes the run length, so the start-to-done cycle count exposes it at the end of every run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   localparam int NUM_ELEM = 6;
   localparam int SES_W    = 3;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EXPORT, ST_DONE} bist_state_e;

   // number of operations in element e (1 or 2)
   function automatic logic [1:0] elem_ops(input logic [SES_W-1:0] e);
      return (e == 3'd0 || e == 3'd5) ? 2'd2 - 2'd1 : 2'd2;
   endfunction

   // element walks addresses from the top down
   function automatic logic elem_down(input logic [SES_W-1:0] e);
      return (e == 3'd3) || (e == 3'd4);
   endfunction

   // operation op of element e is a read
   function automatic logic op_reads(input logic [SES_W-1:0] e, input logic op);
      return (e == 3'd5) || ((e != 3'd0) && !op);
   endfunction

   // data bit written, or expected on read, by the operation
   function automatic logic op_value(input logic [SES_W-1:0] e, input logic op);
      return op_reads(e, op) ? ((e == 3'd2) || (e == 3'd4))
                             : ((e == 3'd1) || (e == 3'd3));
   endfunction

endpackage

// File: rtl/mbist_march_seq.sv
module mbist_march_seq
   import mbist_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   output logic [SES_W-1:0] elem,
   output logic             op,
   output logic [AW-1:0]    addr,
   output logic             addr_done,
   output logic             seq_end
);

   localparam logic [AW-1:0] ADDR_TOP = '1;

   logic             last_addr;
   logic [SES_W-1:0] elem_nxt;

   assign elem_nxt  = elem + 1'b1;
   assign addr_done = (op == (elem_ops(elem) == 2'd2));
   assign last_addr = elem_down(elem) ? (addr == '0) : (addr == ADDR_TOP);
   assign seq_end   = addr_done && last_addr && (elem == SES_W'(NUM_ELEM - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elem <= '0;
         op   <= 1'b0;
         addr <= '0;
      end else if (restart) begin
         elem <= '0;
         op   <= 1'b0;
         addr <= '0;
      end else if (step) begin
         if (!addr_done) begin
            op <= 1'b1;
         end else begin
            op <= 1'b0;
            if (last_addr) begin
               if (!seq_end) begin
                  elem <= elem_nxt;
                  addr <= elem_down(elem_nxt) ? ADDR_TOP : '0;
               end
            end else begin
               addr <= elem_down(elem) ? addr - 1'b1 : addr + 1'b1;
            end
         end
      end
   end

   AST_WALK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step && addr_done && !last_addr && elem_down(elem)) |=> addr == $past(addr) - 1'b1); // R2
   AST_WALK_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && addr_done && !last_addr && !elem_down(elem)) |=> addr == $past(addr) + 1'b1); // R2
   AST_HOLD_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !restart) |=> ($stable(addr) && $stable(elem) && $stable(op))); // R5

endmodule

// File: rtl/mbist_bitpos.sv
module mbist_bitpos #(
   parameter int DW = 8,
   localparam int PW = $clog2(DW)
) (
   input  logic [DW-1:0] syn,
   output logic [PW-1:0] pos,
   output logic          multi
);

   logic [DW:0]   seen;
   logic [DW-1:0] dup;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < DW; i++) begin : g_chain
      assign seen[i+1] = seen[i] | syn[i];
      assign dup[i]    = seen[i] & syn[i];
   end

   assign multi = |dup;

   always_comb begin
      pos = '0;
      for (int i = DW - 1; i >= 0; i--) begin
         if (syn[i]) pos = PW'(i);
      end
   end

endmodule

// File: rtl/mbist_diag_shift.sv
module mbist_diag_shift #(
   parameter int W = 14,
   localparam int CW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] rec,
   output logic         sout,
   output logic         valid,
   output logic         last
);

   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         cnt   <= '0;
         valid <= 1'b0;
      end else if (load) begin
         sh    <= rec;
         cnt   <= CW'(W - 1);
         valid <= 1'b1;
      end else if (valid) begin
         sh <= {sh[W-2:0], 1'b0};
         if (cnt == '0) valid <= 1'b0;
         else           cnt   <= cnt - 1'b1;
      end
   end

   assign sout = sh[W-1];
   assign last = valid && (cnt == '0);

   // checker: length of every valid burst
   logic [CW:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_len <= '0;
      else if (valid) run_len <= run_len + 1'b1;
      else            run_len <= '0;
   end

   AST_REC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid) |-> (run_len == (CW+1)'(W))); // R4
   AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !load); // R3

endmodule

// File: rtl/mbist_march_diag.sv
module mbist_march_diag
   import mbist_pkg::*;
#(
   parameter int AW = 3,
   parameter int DW = 8,
   localparam int REC_W = SES_W + AW + DW,
   localparam int PW    = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   output logic          ram_we,
   input  logic [DW-1:0] ram_rdata,
   output logic          done,
   output logic          fault,
   output logic          diag_bit,
   output logic          diag_valid,
   output logic [PW-1:0] err_pos,
   output logic          err_multi
);

   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("AW must lie in 1..16");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end

   bist_state_e      state_q;
   logic [SES_W-1:0] elem;
   logic             op, addr_done, seq_end;
   logic [AW-1:0]    addr;
   logic             run, restart, capture, is_rd, sh_last, fin_q;
   logic [DW-1:0]    word, syn, acc_q, acc_nxt, last_syn_q;

   assign run     = (state_q == ST_RUN);
   assign restart = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

   mbist_march_seq #(.AW(AW)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .step      (run),
      .elem      (elem),
      .op        (op),
      .addr      (addr),
      .addr_done (addr_done),
      .seq_end   (seq_end)
   );

   assign is_rd     = op_reads(elem, op);
   assign word      = {DW{op_value(elem, op)}};
   assign ram_addr  = addr;
   assign ram_wdata = word;
   assign ram_we    = run && !is_rd;

   assign syn     = (run && is_rd) ? (ram_rdata ^ word) : '0;
   assign acc_nxt = (op ? acc_q : '0) | syn;
   assign capture = run && addr_done && (acc_nxt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         acc_q      <= '0;
         fin_q      <= 1'b0;
         fault      <= 1'b0;
         last_syn_q <= '0;
      end else begin
         if (run) acc_q <= acc_nxt;
         if (restart) begin
            fault      <= 1'b0;
            last_syn_q <= '0;
         end else if (capture) begin
            fault      <= 1'b1;
            last_syn_q <= acc_nxt;
            fin_q      <= seq_end;
         end
         unique case (state_q)
            ST_IDLE, ST_DONE: if (restart) state_q <= ST_RUN;
            ST_RUN: begin
               if (capture)      state_q <= ST_EXPORT;
               else if (seq_end) state_q <= ST_DONE;
            end
            ST_EXPORT: if (sh_last) state_q <= fin_q ? ST_DONE : ST_RUN;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done = (state_q == ST_DONE);

   mbist_diag_shift #(.W(REC_W)) i_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (capture),
      .rec   ({elem, addr, acc_nxt}),
      .sout  (diag_bit),
      .valid (diag_valid),
      .last  (sh_last)
   );

   mbist_bitpos #(.DW(DW)) i_pos (
      .syn   (last_syn_q),
      .pos   (err_pos),
      .multi (err_multi)
   );

   AST_PAUSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      diag_valid |-> !ram_we); // R5
   AST_ONE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !capture); // R3
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!diag_valid && !ram_we)); // R8
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault) |-> $past(start)); // R6
   AST_POS_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (last_syn_q != '0) |-> last_syn_q[err_pos]); // R7
   AST_MULTI_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      err_multi |-> ($countones(last_syn_q) > 1)); // R7

endmodule

// File: tb/test_mbist_march_diag.sv
`timescale 1ns/1ps
module test_mbist_march_diag;

   localparam int AW = 3, DW = 8, PW = 3, REC_W = 14, WORDS = 8;
   localparam int BASE_CYC = 10 * WORDS + 1;
   localparam int NVEC = 5;
   // each entry: {faulty address, stuck-at-1 mask, stuck-at-0 mask}
   localparam logic [18:0] VECS [NVEC] = '{
      {3'd3, 8'h10, 8'h00},
      {3'd0, 8'h00, 8'h01},
      {3'd7, 8'h81, 8'h00},
      {3'd5, 8'h02, 8'h40},
      {3'd0, 8'h00, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata, ram_rdata;
   logic ram_we, done, fault, diag_bit, diag_valid, err_multi;
   logic [PW-1:0] err_pos;

   always #2 clk = ~clk;

   mbist_march_diag #(.AW(AW), .DW(DW)) i_mbist_march_diag (
      .clk(clk), .rst_n(rst_n), .start(start), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
      .done(done), .fault(fault), .diag_bit(diag_bit), .diag_valid(diag_valid),
      .err_pos(err_pos), .err_multi(err_multi));

   logic [DW-1:0] mem [WORDS];
   logic [DW-1:0] sa1_m [WORDS];
   logic [DW-1:0] sa0_m [WORDS];

   always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
   assign ram_rdata = (mem[ram_addr] & ~sa0_m[ram_addr]) | sa1_m[ram_addr];

   int checks = 0, fails = 0;
   logic [REC_W-1:0] got [16];
   logic [REC_W-1:0] expq [16];
   int n_got, n_exp, nb, run_len, bad_len;
   logic [REC_W-1:0] sh;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic clear_faults();
      for (int i = 0; i < WORDS; i++) begin
         sa1_m[i] = '0;
         sa0_m[i] = '0;
      end
   endtask

   task automatic collect();
      if (diag_valid) begin
         sh = {sh[REC_W-2:0], diag_bit};
         nb++;
         run_len++;
         if (nb == REC_W) begin
            if (n_got < 16) got[n_got] = sh;
            n_got++;
            nb = 0;
         end
      end else if (run_len != 0) begin
         if (run_len != REC_W) bad_len++;
         run_len = 0;
      end
   endtask

   task automatic run_march(output int cyc);
      n_got = 0; nb = 0; run_len = 0; bad_len = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 1;
      while (!done && cyc < 3000) begin
         collect();
         @(negedge clk);
         cyc++;
      end
      chk(done, "R8 watchdog: run finished", done, 1);
   endtask

   task automatic compare(input string req);
      chk(n_got == n_exp, {req, " record count"}, n_got, n_exp);
      for (int i = 0; i < n_exp && i < n_got; i++)
         chk(got[i] == expq[i], {req, " record contents"}, got[i], expq[i]);
      chk(bad_len == 0, "R4 diag_valid burst length", bad_len, 0);
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int cyc;
      logic [2:0] a;
      logic [7:0] s1, s0, sy, ls;
      int epos;
      clear_faults();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done && !fault && !diag_valid && !ram_we, "R1 reset outputs",
          {done, fault, diag_valid, ram_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !fault && !diag_valid && !ram_we, "R1 idle after reset",
          {done, fault, diag_valid, ram_we}, 0);

      // table-driven single-address faults
      for (int v = 0; v < NVEC; v++) begin
         {a, s1, s0} = VECS[v];
         clear_faults();
         sa1_m[a] = s1;
         sa0_m[a] = s0;
         n_exp = 0; ls = '0;
         for (int e = 1; e <= 5; e++) begin
            sy = (e % 2 == 1) ? s1 : s0;
            if (sy != '0) begin
               expq[n_exp] = {3'(e), a, sy};
               n_exp++;
               ls = sy;
            end
         end
         run_march(cyc);
         compare("R3");
         chk(cyc == BASE_CYC + REC_W * n_exp, "R5 run length with pauses",
             cyc, BASE_CYC + REC_W * n_exp);
         chk(fault == (n_exp != 0), "R6 fault flag", fault, n_exp != 0);
         epos = 0;
         for (int b = DW - 1; b >= 0; b--) if (ls[b]) epos = b;
         chk(err_pos == PW'(epos), "R7 error bit position", err_pos, epos);
         chk(err_multi == ($countones(ls) > 1), "R7 multi-bit flag",
             err_multi, $countones(ls) > 1);
      end

      // R2: two faulty words, order follows element direction
      clear_faults();
      sa1_m[2] = 8'h08;
      sa1_m[5] = 8'h08;
      expq[0] = {3'd1, 3'd2, 8'h08};
      expq[1] = {3'd1, 3'd5, 8'h08};
      expq[2] = {3'd3, 3'd5, 8'h08};
      expq[3] = {3'd3, 3'd2, 8'h08};
      expq[4] = {3'd5, 3'd2, 8'h08};
      expq[5] = {3'd5, 3'd5, 8'h08};
      n_exp = 6;
      run_march(cyc);
      compare("R2");
      chk(cyc == BASE_CYC + REC_W * 6, "R5 two-word run length", cyc, BASE_CYC + REC_W * 6);

      // R8: done holds and block stays quiet
      repeat (5) begin
         @(negedge clk);
         chk(done && !diag_valid && !ram_we, "R8 done held quiet",
             {done, diag_valid, ram_we}, 4);
      end

      // R6: fault-free restart clears the flag
      clear_faults();
      n_exp = 0;
      run_march(cyc);
      compare("R6");
      chk(!fault, "R6 fault cleared by start", fault, 0);
      chk(err_pos == '0 && !err_multi, "R7 decode cleared", {err_pos, err_multi}, 0);

      summary();
      $finish;
   end

endmodule